// File: doc/BRIEF.md
# Frame alignment character replacer

This block sits on a link transmitter's octet stream while the link carries sample data. It watches the final octet of every frame and, when the active mode says so, swaps that octet for an alignment control character. The receiver can then confirm on an ongoing basis that it is still locked to frame and multiframe boundaries. The upstream logic supplies each octet with a valid strobe and a frame-end marker. It also supplies a flag that says the link is in its data phase, plus two mode flags: one for scrambling and one for lane synchronization.

Within a multiframe, frames are counted by an internal counter. Its length is the parameter `FRAMES_PER_MF`, and the counter restarts each time the data phase is entered. Octets that are not replaced leave the block unchanged, one clock later, with the K flag low. A replaced octet carries either K28.7 (0xFC) or K28.3 (0x7C), with the K flag high.

Top module: `frame_align_replacer`

## Requirements
- R1: Reset and register behaviour. While `rst_n` is low, `out_valid`, `out_is_k` and `out_octet` are all zero. After reset, the first frame is never replaced.
- R2: Pass-through. Each accepted octet appears on `out_octet` one clock cycle after it is presented. `out_valid` is high in that cycle. When no replacement applies, `out_is_k` is low.
- R3: Scrambling off, lane sync on, frame not ending a multiframe. A frame-end octet that equals the original frame-end octet of the previous frame is output as 0xFC with `out_is_k` high.
- R4: Scrambling off, lane sync on, frame ending a multiframe. A repeated frame-end octet is output as 0x7C with `out_is_k` high.
- R5: Scrambling off, lane sync off. A repeated frame-end octet is output as 0xFC with `out_is_k` high, whatever the multiframe position.
- R6: Scrambling on, lane sync on, frame not ending a multiframe. A frame-end octet of 0xFC becomes K 0xFC. A frame-end octet of 0x7C passes through as data.
- R7: Scrambling on, lane sync on, frame ending a multiframe. A frame-end octet of 0x7C becomes K 0x7C. A frame-end octet of 0xFC passes through as data.
- R8: Scrambling on, lane sync off. A frame-end octet of 0xFC becomes K 0xFC at any position, and 0x7C passes through as data. A K output is only ever 0xFC or 0x7C.
- R9: An octet without `in_eof` is never replaced, even when it equals 0xFC, 0x7C or the previous frame-end octet.
- R10: The previous-frame comparison uses the original octet value, not the replaced one, so every frame in a run of identical frames is replaced.
- R11: Frames are numbered 0 to `FRAMES_PER_MF`-1, counting from the first frame after the data phase is entered. Frame `FRAMES_PER_MF`-1 ends the multiframe, and the numbering then wraps to 0.
- R12: While `data_phase` is low, no octet is replaced, and both the stored previous octet and the frame count are cleared. The first frame-end octet after re-entry is therefore never replaced, even when it matches the octet stored before.
- R13: A cycle with `in_valid` low gives `out_valid` and `out_is_k` low in the next cycle, and it does not advance the frame count or the stored previous octet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_phase | input | 1 | High while the link transmits sample data |
| scramble_en | input | 1 | Scrambling mode selected |
| lanesync_en | input | 1 | Lane synchronization mode selected |
| in_valid | input | 1 | An octet is presented this cycle |
| in_eof | input | 1 | The presented octet is the last one of its frame |
| in_octet | input | 8 | Octet from the framer |
| out_valid | output | 1 | Output octet valid |
| out_is_k | output | 1 | Output octet is a control character |
| out_octet | output | 8 | Octet or replacement character |

## Verification
The checker tests several properties on every cycle:
- the one-cycle valid timing;
- that octets in the middle of a frame, and octets outside the data phase, always pass through unchanged;
- that idle cycles never produce a K flag;
- that any K output is one of the two alignment codes;
- that scrambled data without lane sync is never replaced unless it is 0xFC.

Whether a given frame-end octet is replaced depends on history that only scenarios can set up. This includes:
- the repetition of the previous frame's octet;
- where the frame falls in the multiframe;
- the restart of counting after re-entry into the data phase;
- the use of original octets when runs of frames are identical.

The bench covers these with a walked vector table across all four mode combinations.

// File: rtl/fa_pkg.sv
`timescale 1ns/1ps
package fa_pkg;
    localparam int OCTET_W = 8;
    localparam logic [OCTET_W-1:0] K28_7 = 8'hFC;  // also the value of data D28.7
    localparam logic [OCTET_W-1:0] K28_3 = 8'h7C;  // also the value of data D28.3

    typedef struct packed {
        logic               vld;
        logic               is_k;
        logic [OCTET_W-1:0] oct;
    } fa_out_t;
endpackage

// File: rtl/fa_mf_counter.sv
`timescale 1ns/1ps
// Frame position inside the multiframe (R11).
module fa_mf_counter #(
    parameter int FRAMES_PER_MF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic frame_done,
    output logic last_frame
);
    localparam int CNT_W = (FRAMES_PER_MF > 1) ? $clog2(FRAMES_PER_MF) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAMES_PER_MF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } mf_state_t;

    mf_state_t st_d, st_q;

    generate
        if (FRAMES_PER_MF > 1) begin : g_count
            assign last_frame = (st_q.cnt == LAST_IDX);
        end else begin : g_single
            assign last_frame = 1'b1;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (frame_done) begin
            if (st_q.cnt == LAST_IDX) st_d.cnt = '0;
            else                      st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fa_prev_tracker.sv
`timescale 1ns/1ps
// Holds the original last octet of the previous frame (R10, R12).
module fa_prev_tracker
    import fa_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               capture,
    input  logic [OCTET_W-1:0] octet_in,
    output logic [OCTET_W-1:0] prev_octet,
    output logic               prev_valid
);
    typedef struct packed {
        logic               vld;
        logic [OCTET_W-1:0] oct;
    } prev_state_t;

    prev_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (capture) begin
            st_d.vld = 1'b1;
            st_d.oct = octet_in;   // the unreplaced value
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prev_octet = st_q.oct;
    assign prev_valid = st_q.vld;
endmodule

// File: rtl/fa_replace_rule.sv
`timescale 1ns/1ps
// Mode-dependent replacement decision (R3..R9).
module fa_replace_rule
    import fa_pkg::*;
(
    input  logic               active,
    input  logic               eof,
    input  logic               mf_last,
    input  logic               scr_en,
    input  logic               ls_en,
    input  logic [OCTET_W-1:0] octet,
    input  logic [OCTET_W-1:0] prev_octet,
    input  logic               prev_valid,
    output logic               replace,
    output logic [OCTET_W-1:0] k_code
);
    logic hit;

    always_comb begin
        hit    = 1'b0;
        k_code = K28_7;
        if (!scr_en) begin
            hit    = prev_valid && (octet == prev_octet);
            k_code = (ls_en && mf_last) ? K28_3 : K28_7;
        end else if (ls_en && mf_last) begin
            hit    = (octet == K28_3);
            k_code = K28_3;
        end else begin
            hit    = (octet == K28_7);
            k_code = K28_7;
        end
        replace = active && eof && hit;
    end
endmodule

// File: rtl/frame_align_replacer.sv
`timescale 1ns/1ps
module frame_align_replacer
    import fa_pkg::*;
#(
    parameter int FRAMES_PER_MF = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_phase,
    input  logic               scramble_en,
    input  logic               lanesync_en,
    input  logic               in_valid,
    input  logic               in_eof,
    input  logic [OCTET_W-1:0] in_octet,
    output logic               out_valid,
    output logic               out_is_k,
    output logic [OCTET_W-1:0] out_octet
);
    logic               active;
    logic               frame_done;
    logic               mf_last;
    logic [OCTET_W-1:0] prev_octet;
    logic               prev_valid;
    logic               replace;
    logic [OCTET_W-1:0] k_code;

    fa_out_t out_d, out_q;

    assign active     = in_valid && data_phase;
    assign frame_done = active && in_eof;

    fa_mf_counter #(.FRAMES_PER_MF(FRAMES_PER_MF)) i_mf_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (!data_phase),
        .frame_done (frame_done),
        .last_frame (mf_last)
    );

    fa_prev_tracker i_prev_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (!data_phase),
        .capture    (frame_done),
        .octet_in   (in_octet),
        .prev_octet (prev_octet),
        .prev_valid (prev_valid)
    );

    fa_replace_rule i_replace_rule (
        .active     (active),
        .eof        (in_eof),
        .mf_last    (mf_last),
        .scr_en     (scramble_en),
        .ls_en      (lanesync_en),
        .octet      (in_octet),
        .prev_octet (prev_octet),
        .prev_valid (prev_valid),
        .replace    (replace),
        .k_code     (k_code)
    );

    // One register stage on the output (R2).
    always_comb begin
        out_d      = out_q;
        out_d.vld  = in_valid;
        out_d.is_k = 1'b0;
        if (in_valid) begin
            out_d.oct = replace ? k_code : in_octet;
            out_d.is_k = replace;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;   // R1
        else        out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign out_is_k  = out_q.is_k;
    assign out_octet = out_q.oct;
endmodule

// File: rtl/frame_align_replacer_chk.sv
`timescale 1ns/1ps
module frame_align_replacer_chk
    import fa_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               data_phase,
    input logic               scramble_en,
    input logic               lanesync_en,
    input logic               in_valid,
    input logic               in_eof,
    input logic [OCTET_W-1:0] in_octet,
    input logic               out_valid,
    input logic               out_is_k,
    input logic [OCTET_W-1:0] out_octet
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_is_k));

    a_r9_mid_frame_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_eof) |=> (!out_is_k && out_octet == $past(in_octet)));

    a_r12_no_replace_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !data_phase) |=> (!out_is_k && out_octet == $past(in_octet)));

    a_r8_k_codes_only: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_k |-> (out_octet == K28_7 || out_octet == K28_3));

    a_r8_scr_nolane_only_fc: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof && scramble_en && !lanesync_en && in_octet != K28_7)
        |=> !out_is_k);
endmodule

bind frame_align_replacer frame_align_replacer_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_phase  (data_phase),
    .scramble_en (scramble_en),
    .lanesync_en (lanesync_en),
    .in_valid    (in_valid),
    .in_eof      (in_eof),
    .in_octet    (in_octet),
    .out_valid   (out_valid),
    .out_is_k    (out_is_k),
    .out_octet   (out_octet)
);

// File: tb/test_frame_align_replacer.sv
`timescale 1ns/1ps
module test_frame_align_replacer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_phase = 1'b0;
    logic       scramble_en = 1'b0;
    logic       lanesync_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_eof = 1'b0;
    logic [7:0] in_octet = 8'h00;
    logic       out_valid;
    logic       out_is_k;
    logic [7:0] out_octet;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    frame_align_replacer #(.FRAMES_PER_MF(4)) i_frame_align_replacer (
        .clk(clk), .rst_n(rst_n), .data_phase(data_phase),
        .scramble_en(scramble_en), .lanesync_en(lanesync_en),
        .in_valid(in_valid), .in_eof(in_eof), .in_octet(in_octet),
        .out_valid(out_valid), .out_is_k(out_is_k), .out_octet(out_octet)
    );

    // {req[25:22], dp, valid, eof, scr, ls, octet[16:9], exp_k, exp_octet[7:0]}
    localparam int NV = 46;
    localparam logic [25:0] VEC [NV] = '{
        {4'd2,  5'b11001, 8'h11, 1'b0, 8'h11},  // R2 frame0 first octet
        {4'd12, 5'b11101, 8'h22, 1'b0, 8'h22},  // R12 first frame never replaced
        {4'd2,  5'b11001, 8'h33, 1'b0, 8'h33},
        {4'd3,  5'b11101, 8'h22, 1'b1, 8'hFC},  // R3 repeat, frame1
        {4'd9,  5'b11001, 8'h22, 1'b0, 8'h22},  // R9 equal but not frame end
        {4'd10, 5'b11101, 8'h22, 1'b1, 8'hFC},  // R10 frame2 still replaced
        {4'd2,  5'b11001, 8'h00, 1'b0, 8'h00},
        {4'd4,  5'b11101, 8'h22, 1'b1, 8'h7C},  // R4 frame3 ends multiframe
        {4'd13, 5'b10101, 8'h22, 1'b0, 8'h00},  // R13 idle cycle
        {4'd2,  5'b11001, 8'h01, 1'b0, 8'h01},
        {4'd11, 5'b11101, 8'h55, 1'b0, 8'h55},  // R11 frame0 of next multiframe
        {4'd2,  5'b11000, 8'h02, 1'b0, 8'h02},
        {4'd5,  5'b11100, 8'h55, 1'b1, 8'hFC},  // R5 frame1
        {4'd2,  5'b11000, 8'h03, 1'b0, 8'h03},
        {4'd5,  5'b11100, 8'h55, 1'b1, 8'hFC},  // R5 frame2
        {4'd2,  5'b11000, 8'h04, 1'b0, 8'h04},
        {4'd5,  5'b11100, 8'h55, 1'b1, 8'hFC},  // R5 frame3, still K28.7
        {4'd9,  5'b11011, 8'hFC, 1'b0, 8'hFC},  // R9 0xFC mid frame
        {4'd6,  5'b11111, 8'hFC, 1'b1, 8'hFC},  // R6 frame0
        {4'd2,  5'b11011, 8'h20, 1'b0, 8'h20},
        {4'd6,  5'b11111, 8'h7C, 1'b0, 8'h7C},  // R6 0x7C not at multiframe end
        {4'd2,  5'b11011, 8'h21, 1'b0, 8'h21},
        {4'd11, 5'b11111, 8'h44, 1'b0, 8'h44},  // R11 frame2
        {4'd2,  5'b11011, 8'h22, 1'b0, 8'h22},
        {4'd7,  5'b11111, 8'hFC, 1'b0, 8'hFC},  // R7 0xFC at multiframe end
        {4'd2,  5'b11011, 8'h23, 1'b0, 8'h23},
        {4'd11, 5'b11111, 8'h99, 1'b0, 8'h99},
        {4'd2,  5'b11011, 8'h24, 1'b0, 8'h24},
        {4'd11, 5'b11111, 8'h00, 1'b0, 8'h00},
        {4'd2,  5'b11011, 8'h25, 1'b0, 8'h25},
        {4'd11, 5'b11111, 8'h00, 1'b0, 8'h00},
        {4'd2,  5'b11011, 8'h26, 1'b0, 8'h26},
        {4'd7,  5'b11111, 8'h7C, 1'b1, 8'h7C},  // R7 K28.3 at multiframe end
        {4'd2,  5'b11010, 8'h27, 1'b0, 8'h27},
        {4'd8,  5'b11110, 8'h7C, 1'b0, 8'h7C},  // R8 0x7C passes
        {4'd2,  5'b11010, 8'h28, 1'b0, 8'h28},
        {4'd8,  5'b11110, 8'hFC, 1'b1, 8'hFC},  // R8 0xFC replaced
        {4'd12, 5'b01101, 8'h33, 1'b0, 8'h33},  // R12 outside data phase
        {4'd2,  5'b11001, 8'h00, 1'b0, 8'h00},
        {4'd12, 5'b11101, 8'hFC, 1'b0, 8'hFC},  // R12 stored octet was cleared
        {4'd2,  5'b11001, 8'h00, 1'b0, 8'h00},
        {4'd3,  5'b11101, 8'hFC, 1'b1, 8'hFC},
        {4'd2,  5'b11001, 8'h00, 1'b0, 8'h00},
        {4'd10, 5'b11101, 8'hFC, 1'b1, 8'hFC},
        {4'd2,  5'b11001, 8'h00, 1'b0, 8'h00},
        {4'd11, 5'b11101, 8'hFC, 1'b1, 8'h7C}   // R11 count restarted on entry
    };

    task automatic check(input int req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual k/octet=%0b/%h expected %0b/%h",
                     req, act[8], act[7:0], exp[8], exp[7:0]);
        end
    endtask

    task automatic check_reset_state();
        // R1: all outputs zero under reset
        check(1, {out_is_k | out_valid, out_octet}, 9'h000);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        check_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        data_phase = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            data_phase  = VEC[i][21];
            in_valid    = VEC[i][20];
            in_eof      = VEC[i][19];
            scramble_en = VEC[i][18];
            lanesync_en = VEC[i][17];
            in_octet    = VEC[i][16:9];
            @(posedge clk);
            #1;
            if (VEC[i][20]) begin
                check(int'(VEC[i][25:22]), {1'b0, 7'd0, out_valid}, 9'h001);
                check(int'(VEC[i][25:22]), {out_is_k, out_octet}, VEC[i][8:0]);
            end else begin
                check(13, {out_is_k, 7'd0, out_valid}, 9'h000);  // R13
            end
        end

        // R1: reset in the middle of a repeated run
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1; in_eof = 1'b1; scramble_en = 1'b0; lanesync_en = 1'b1;
        in_octet = 8'hFC;
        @(posedge clk);
        #1;
        check_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(1, {out_is_k, out_octet}, {1'b0, 8'hFC});  // R1 first frame after reset
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check(13, {out_is_k, 7'd0, out_valid}, 9'h000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule